// File: doc/BRIEF.md
# USB Interrupt Status Register

This block holds the 16-bit interrupt status word of a combined USB host/device controller. Two lines arrive asynchronously and are synchronized inside the block: the VBUS sense pin and the DP data line. A change of the VBUS level in either direction latches a flag, and the live synchronized VBUS level can be read at any time. Software re-reads that level to filter chattering. A falling edge on DP latches a resume flag, but only while the device-state field holds a suspended code and the block runs in device mode.

The SOF, device-state-transition, control-stage-transition and setup-valid events come from sequencers outside the block as one-cycle pulses. They set sticky flags. The buffer-empty, not-ready and buffer-ready summaries are passed straight through as live levels. The device-state and control-stage codes are held in registers that their sequencers load. Software clears a sticky flag by writing 0 to its bit. An interrupt output combines the flag bits with a separate enable word.

There are two reset domains. The asynchronous power-on reset clears everything the block stores. A synchronous USB bus reset clears only the device-state field.

Top module: `usb_irq_status_reg`

## Requirements
- R1: A level change of `vbus_in` in either direction, after synchronization, sets bit 15 of `rd_data`. The bit reads 1 no later than three clock edges after the change.
- R2: Bit 7 of `rd_data` shows the synchronized `vbus_in` level, two clock edges behind the input. It ignores writes.
- R3: A falling edge of `dp_in` sets bit 14 when two conditions hold: `host_mode` is 0, and bit 6 (the MSB of the device-state field, bits 6:4) is 1.
- R4: A falling edge of `dp_in` while bit 6 is 0 leaves bit 14 at 0. A rising edge of `dp_in` also leaves bit 14 at 0, even while the device is suspended.
- R5: While `host_mode` is 1, bit 14 reads 0 from the next clock edge on and is never set.
- R6: Writing with `wr_en` clears each sticky flag (bits 15, 14, 13, 12, 11 and 3) whose `wr_data` bit is 0. A flag whose `wr_data` bit is 1 is left unchanged.
- R7: If a set event and a clearing write reach the same flag in the same cycle, the flag ends at 1.
- R8: The power-on reset `rst_n`=0 clears bits 15:11, 6:4, 3 and 2:0. Bits 10:8 read the live `bemp_lvl`, `nrdy_lvl` and `brdy_lvl` inputs, in that order.
- R9: A `bus_rst` pulse clears bits 6:4 to 0 on the next edge and leaves every other bit unchanged. A bus reset has priority over a device-state load in the same cycle.
- R10: `irq` is 1 exactly when some bit in 15:8 or bit 3 of `rd_data` is 1 together with the same bit of `irq_en`. Bits 7, 6:4 and 2:0 never drive `irq`.
- R11: Filling the synchronizers after power-on reset is not counted as an edge. With `vbus_in` held high through reset, bit 15 stays 0.
- R12: Writes do not change bits 10:4 or 2:0. The device-state field changes only through `dev_state_ld` and the control-stage field only through `ctrl_stage_ld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| bus_rst | input | 1 | USB bus reset pulse, synchronous |
| host_mode | input | 1 | 1 = host operation, 0 = device operation |
| vbus_in | input | 1 | VBUS sense pin, asynchronous |
| dp_in | input | 1 | DP line level, asynchronous |
| sof_evt | input | 1 | SOF event pulse (sets bit 13) |
| dvst_evt | input | 1 | Device-state transition pulse (sets bit 12) |
| ctrt_evt | input | 1 | Control-stage transition pulse (sets bit 11) |
| valid_evt | input | 1 | Setup-received pulse (sets bit 3) |
| bemp_lvl | input | 1 | Buffer-empty summary, shown in bit 10 |
| nrdy_lvl | input | 1 | Not-ready summary, shown in bit 9 |
| brdy_lvl | input | 1 | Buffer-ready summary, shown in bit 8 |
| dev_state_ld | input | 1 | Load strobe for the device-state field |
| dev_state_in | input | 3 | New device-state code |
| ctrl_stage_ld | input | 1 | Load strobe for the control-stage field |
| ctrl_stage_in | input | 3 | New control-stage code |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data, a 0 clears a sticky flag |
| irq_en | input | 16 | Interrupt enable per bit |
| rd_data | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- an internal VBUS edge sets bit 15 on the next edge, and a set event wins over a clearing write;
- a clearing write without a set event leaves the flag at 0;
- host mode keeps bit 14 at 0;
- a bus reset zeroes bits 6:4 and keeps the control stage;
- `irq` agrees with the enabled flags.

Some behaviour shows only in the bench's scenarios, because it depends on the input history. This covers:
- the synchronizer latency on both VBUS directions;
- the absence of a start-up edge with VBUS high through reset;
- DP falling edges with non-suspended and suspended device-state codes, and a DP rising edge;
- read-only bits that survive writes of all zeros.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_W      = 16;
  localparam int FIELD_W    = 3;
  localparam int SYNC_DEPTH = 2;
  localparam int NFLAG      = 6;

  // bit positions of the status word
  localparam int B_VBINT = 15;
  localparam int B_RESM  = 14;
  localparam int B_SOF   = 13;
  localparam int B_DVST  = 12;
  localparam int B_CTRT  = 11;
  localparam int B_BEMP  = 10;
  localparam int B_NRDY  = 9;
  localparam int B_BRDY  = 8;
  localparam int B_VBLVL = 7;
  localparam int B_DSLO  = 4;
  localparam int B_VALID = 3;
  localparam int B_CSLO  = 0;

  // flag bank slots
  localparam int F_VALID = 0;
  localparam int F_CTRT  = 1;
  localparam int F_DVST  = 2;
  localparam int F_SOF   = 3;
  localparam int F_RESM  = 4;
  localparam int F_VBINT = 5;

  localparam logic [REG_W-1:0] IRQ_SRC_MASK = 16'hFF08;

  function automatic int flag_pos(input int slot);
    case (slot)
      F_VALID: flag_pos = B_VALID;
      F_CTRT:  flag_pos = B_CTRT;
      F_DVST:  flag_pos = B_DVST;
      F_SOF:   flag_pos = B_SOF;
      F_RESM:  flag_pos = B_RESM;
      default: flag_pos = B_VBINT;
    endcase
  endfunction
endpackage

// File: rtl/usb_edge_sync.sv
module usb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic [STAGES:0]   fill_q, fill_d;
  logic              prev_q, prev_d;
  logic              armed;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_in};
    fill_d  = {fill_q[STAGES-1:0], 1'b1};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      fill_q  <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      fill_q  <= fill_d;
      prev_q  <= prev_d;
    end
  end

  assign armed = fill_q[STAGES];
  assign level = chain_q[STAGES-1];
  assign rise  = armed &  level & ~prev_q;
  assign fall  = armed & ~level &  prev_q;
endmodule

// File: rtl/usb_w0c_bank.sv
module usb_w0c_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] wclr_i,
  input  logic [N-1:0] hold0_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_comb begin
      if (hold0_i[i])      flag_d[i] = 1'b0;
      else if (set_i[i])   flag_d[i] = 1'b1;
      else if (wclr_i[i])  flag_d[i] = 1'b0;
      else                 flag_d[i] = flag_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/usb_field_reg.sv
module usb_field_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclr_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q, d;
  logic         en;

  always_comb begin
    en = sclr_i | ld_i;
    d  = sclr_i ? '0 : d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/usb_irq_status_reg.sv
module usb_irq_status_reg
  import usb_irq_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rst,
  input  logic               host_mode,
  input  logic               vbus_in,
  input  logic               dp_in,
  input  logic               sof_evt,
  input  logic               dvst_evt,
  input  logic               ctrt_evt,
  input  logic               valid_evt,
  input  logic               bemp_lvl,
  input  logic               nrdy_lvl,
  input  logic               brdy_lvl,
  input  logic               dev_state_ld,
  input  logic [FIELD_W-1:0] dev_state_in,
  input  logic               ctrl_stage_ld,
  input  logic [FIELD_W-1:0] ctrl_stage_in,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [REG_W-1:0]   irq_en,
  output logic [REG_W-1:0]   rd_data,
  output logic               irq
);
  logic vbus_lvl, vbus_rise, vbus_fall, vbus_edge;
  logic dp_lvl, dp_rise, dp_fall;
  logic [FIELD_W-1:0] dev_state_q, ctrl_stage_q;
  logic [NFLAG-1:0]   flag_set, flag_wclr, flag_hold0, flag_q;
  logic               suspended;

  usb_edge_sync #(.STAGES(SYNC_STAGES)) u_vbus_sync (
    .clk(clk), .rst_n(rst_n), .async_in(vbus_in),
    .level(vbus_lvl), .rise(vbus_rise), .fall(vbus_fall)
  );

  usb_edge_sync #(.STAGES(SYNC_STAGES)) u_dp_sync (
    .clk(clk), .rst_n(rst_n), .async_in(dp_in),
    .level(dp_lvl), .rise(dp_rise), .fall(dp_fall)
  );

  assign vbus_edge = vbus_rise | vbus_fall;

  usb_field_reg #(.W(FIELD_W)) u_dev_state (
    .clk(clk), .rst_n(rst_n), .sclr_i(bus_rst), .ld_i(dev_state_ld),
    .d_i(dev_state_in), .q_o(dev_state_q)
  );

  usb_field_reg #(.W(FIELD_W)) u_ctrl_stage (
    .clk(clk), .rst_n(rst_n), .sclr_i(1'b0), .ld_i(ctrl_stage_ld),
    .d_i(ctrl_stage_in), .q_o(ctrl_stage_q)
  );

  assign suspended = dev_state_q[FIELD_W-1];

  always_comb begin
    flag_set          = '0;
    flag_set[F_VALID] = valid_evt;
    flag_set[F_CTRT]  = ctrt_evt;
    flag_set[F_DVST]  = dvst_evt;
    flag_set[F_SOF]   = sof_evt;
    flag_set[F_RESM]  = dp_fall & suspended & ~host_mode;
    flag_set[F_VBINT] = vbus_edge;
    flag_hold0         = '0;
    flag_hold0[F_RESM] = host_mode;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_wclr
    assign flag_wclr[i] = wr_en & ~wr_data[flag_pos(i)];
  end

  usb_w0c_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .wclr_i(flag_wclr),
    .hold0_i(flag_hold0), .flag_o(flag_q)
  );

  always_comb begin
    rd_data                           = '0;
    rd_data[B_VBINT]                  = flag_q[F_VBINT];
    rd_data[B_RESM]                   = flag_q[F_RESM];
    rd_data[B_SOF]                    = flag_q[F_SOF];
    rd_data[B_DVST]                   = flag_q[F_DVST];
    rd_data[B_CTRT]                   = flag_q[F_CTRT];
    rd_data[B_BEMP]                   = bemp_lvl;
    rd_data[B_NRDY]                   = nrdy_lvl;
    rd_data[B_BRDY]                   = brdy_lvl;
    rd_data[B_VBLVL]                  = vbus_lvl;
    rd_data[B_DSLO+FIELD_W-1:B_DSLO]  = dev_state_q;
    rd_data[B_VALID]                  = flag_q[F_VALID];
    rd_data[B_CSLO+FIELD_W-1:B_CSLO]  = ctrl_stage_q;
  end

  assign irq = |(rd_data & irq_en & IRQ_SRC_MASK);
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rst,
  input logic        host_mode,
  input logic        sof_evt,
  input logic        dvst_evt,
  input logic        ctrl_stage_ld,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] irq_en,
  input logic [15:0] rd_data,
  input logic        irq,
  input logic        vbus_edge,
  input logic        dp_fall
);
  // R1
  vbus_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_edge |=> rd_data[15]);
  // R3
  resume_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_fall && rd_data[6] && !host_mode) |=> rd_data[14]);
  // R4
  resume_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_fall && !rd_data[14]) |=> !rd_data[14]);
  // R5
  host_resume_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode |=> !rd_data[14]);
  // R6
  w0c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[12] && !dvst_evt) |=> !rd_data[12]);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> rd_data[13]);
  // R9
  bus_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (rd_data[6:4] == 3'd0));
  // R9
  bus_rst_keeps_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !ctrl_stage_ld) |=> $stable(rd_data[2:0]));
  // R10
  irq_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[15] && irq_en[15]) || (rd_data[3] && irq_en[3])) |-> irq);
  // R10
  irq_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:8] & irq_en[15:8]) == 8'd0 && !(rd_data[3] && irq_en[3]) |-> !irq);
endmodule

bind usb_irq_status_reg usb_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .host_mode(host_mode),
  .sof_evt(sof_evt), .dvst_evt(dvst_evt), .ctrl_stage_ld(ctrl_stage_ld),
  .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en), .rd_data(rd_data),
  .irq(irq), .vbus_edge(vbus_edge), .dp_fall(dp_fall)
);

// File: tb/sim_usb_irq_status_reg.sv
`timescale 1ns/1ps
module sim_usb_irq_status_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0, host_mode = 1'b0;
  logic vbus_in = 1'b1, dp_in = 1'b1;
  logic sof_evt = 1'b0, dvst_evt = 1'b0, ctrt_evt = 1'b0, valid_evt = 1'b0;
  logic bemp_lvl = 1'b0, nrdy_lvl = 1'b0, brdy_lvl = 1'b0;
  logic dev_state_ld = 1'b0, ctrl_stage_ld = 1'b0;
  logic [2:0] dev_state_in = 3'd0, ctrl_stage_in = 3'd0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = 16'hFFFF, irq_en = 16'h0000;
  logic [15:0] rd_data;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .host_mode(host_mode),
    .vbus_in(vbus_in), .dp_in(dp_in), .sof_evt(sof_evt), .dvst_evt(dvst_evt),
    .ctrt_evt(ctrt_evt), .valid_evt(valid_evt), .bemp_lvl(bemp_lvl),
    .nrdy_lvl(nrdy_lvl), .brdy_lvl(brdy_lvl), .dev_state_ld(dev_state_ld),
    .dev_state_in(dev_state_in), .ctrl_stage_ld(ctrl_stage_ld),
    .ctrl_stage_in(ctrl_stage_in), .wr_en(wr_en), .wr_data(wr_data),
    .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0; wr_data = 16'hFFFF;
  endtask

  task automatic load_state(input logic [2:0] s);
    dev_state_in = s; dev_state_ld = 1'b1;
    tick(1);
    dev_state_ld = 1'b0;
  endtask

  task automatic t_reset;
    // vbus high through reset
    tick(3);
    rst_n = 1'b1;
    tick(6);
    check("R8 flags cleared", rd_data & 16'hF87F, 16'h0000);
    check("R11 no startup edge", {15'd0, rd_data[15]}, 16'd0);
    check("R2 level after reset", {15'd0, rd_data[7]}, 16'd1);
  endtask

  task automatic t_vbus;
    vbus_in = 1'b0;
    tick(1);
    check("R2 level lags", {15'd0, rd_data[7]}, 16'd1);
    tick(2);
    check("R1 falling sets", {15'd0, rd_data[15]}, 16'd1);
    check("R2 level low", {15'd0, rd_data[7]}, 16'd0);
    wr(16'h7FFF);
    check("R6 clear vbus flag", {15'd0, rd_data[15]}, 16'd0);
    vbus_in = 1'b1;
    tick(3);
    check("R1 rising sets", {15'd0, rd_data[15]}, 16'd1);
    wr(16'h7FFF);
  endtask

  task automatic t_resume;
    load_state(3'd2);
    dp_in = 1'b0; tick(4);
    check("R4 no resume unsuspended", {15'd0, rd_data[14]}, 16'd0);
    load_state(3'd5);
    dp_in = 1'b1; tick(4);
    check("R4 no resume on rise", {15'd0, rd_data[14]}, 16'd0);
    dp_in = 1'b0; tick(4);
    check("R3 resume suspended", {15'd0, rd_data[14]}, 16'd1);
    wr(16'hBFFF);
    check("R6 clear resume", {15'd0, rd_data[14]}, 16'd0);
    dp_in = 1'b1; tick(4);
  endtask

  task automatic t_host;
    host_mode = 1'b1;
    load_state(3'd4);
    dp_in = 1'b0; tick(4);
    check("R5 host resume held 0", {15'd0, rd_data[14]}, 16'd0);
    dp_in = 1'b1; tick(4);
    host_mode = 1'b0;
    tick(2);
    check("R5 no late set", {15'd0, rd_data[14]}, 16'd0);
  endtask

  task automatic t_w0c;
    sof_evt = 1'b1; dvst_evt = 1'b1; ctrt_evt = 1'b1; valid_evt = 1'b1;
    tick(1);
    sof_evt = 1'b0; dvst_evt = 1'b0; ctrt_evt = 1'b0; valid_evt = 1'b0;
    check("R6 set flags", rd_data & 16'h3808, 16'h3808);
    wr(16'hFFFF);
    check("R6 write ones keeps", rd_data & 16'h3808, 16'h3808);
    wr(16'hEFF7);
    check("R6 write zero clears 12,3", rd_data & 16'h3808, 16'h2800);
    bemp_lvl = 1'b1; brdy_lvl = 1'b1;
    ctrl_stage_in = 3'd6; ctrl_stage_ld = 1'b1; tick(1); ctrl_stage_ld = 1'b0;
    wr(16'h0000);
    check("R6 all cleared", rd_data & 16'hF808, 16'h0000);
    check("R12 read-only kept", rd_data & 16'h07F7, 16'h05C6);
    check("R8 live bits 10:8", {13'd0, rd_data[10:8]}, 16'd5);
  endtask

  task automatic t_collide;
    sof_evt = 1'b1; wr_data = 16'h0000; wr_en = 1'b1;
    tick(1);
    sof_evt = 1'b0; wr_en = 1'b0; wr_data = 16'hFFFF;
    check("R7 set wins", {15'd0, rd_data[13]}, 16'd1);
  endtask

  task automatic t_busrst;
    // state 4, stage 6, sof flag set
    bus_rst = 1'b1;
    dev_state_in = 3'd7; dev_state_ld = 1'b1;
    tick(1);
    bus_rst = 1'b0; dev_state_ld = 1'b0;
    check("R9 state cleared", {13'd0, rd_data[6:4]}, 16'd0);
    check("R9 others unchanged", rd_data & 16'hFF8F, 16'h2586);
  endtask

  task automatic t_irq;
    irq_en = 16'h2000; tick(1);
    check("R10 enabled flag irq", {15'd0, irq}, 16'd1);
    irq_en = 16'h00F7; tick(1);
    check("R10 fields no irq", {15'd0, irq}, 16'd0);
    irq_en = 16'h0400; tick(1);
    check("R10 bemp irq", {15'd0, irq}, 16'd1);
    irq_en = 16'h0000;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_vbus();
    t_resume();
    t_host();
    t_w0c();
    t_collide();
    t_busrst();
    t_irq();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule